// File: doc/BRIEF.md
# Event Counter with Compare-Driven Output Pins

This block counts time in coarse steps: a fixed prescaler divides the system clock, and each prescaler period advances an up-counter by one. Two compare registers are checked against the counter on every step. A match raises a sticky flag and can drive one of two output pins. A control register chooses how the counter is cleared (held at zero, free running with a wrap flag, cleared by a falling edge on either of two external inputs, or cleared on a match with the second compare register). The same register chooses which events move each pin.

Each pin is not toggled directly. It has a level latch. An event copies the latch to the pin, and the latch can then invert itself, so a series of events gives an alternating waveform. An output-mode register holds the per-pin inversion enables and three one-shot commands per pin: clear the latch, set the latch, and copy the latch to the pin now. The commands act only in the write that carries them. Writes arrive on a simple select/data bus with four targets.

Top module: `evcmp_top`

## Requirements
- R1: Outside the hold mode, the counter advances by exactly one every PRESCALE clocks. After a control write that leaves the hold mode, the count is k at the PRESCALE*k-th clock edge after the write edge.
- R2: When a step brings the count equal to compare A (select 0), flag_cmp_a is set. When it equals compare B (select 1), flag_cmp_b is set. Flags stay set until a 1 is written to flag_clr bit 0 (A), bit 1 (B) or bit 2 (wrap). A set in the same cycle wins over a clear.
- R3: Control bits [5:4] choose the events that move pin A: 00 a compare-A match, 01 none, 10 a compare-A match or a falling ext_ci, 11 a match with either compare. Bits [7:6] do the same for pin B, with compare B in place of compare A in codes 00 and 10.
- R4: Control bits [3:2] = 00 hold the counter and prescaler at zero, so no match occurs. Code 01 runs freely, and flag_wrap is set when a step takes the count to zero.
- R5: Control bits [3:2] = 11 clear the counter on the step where it would equal compare B. flag_cmp_b is still set on that step.
- R6: Control bits [3:2] = 10 clear the counter on a falling edge of ext_ci or ext_to. The clear takes effect on the third clock edge after the input falls, it wins over a step in that cycle, and it does not reset the prescaler phase. Rising edges have no effect.
- R7: In a write to the output-mode register (select 3), field [3:2] acts on latch A: 01 clears it, 10 sets it, and 00 or 11 leave it unchanged. Field [7:6] does the same for latch B. These commands act once and are not stored.
- R8: Output-mode bit 0 (pin A) or bit 4 (pin B), written as 1, copies the latch to the pin in that write. The latch command of the same write is applied first.
- R9: Every pin event, whether from a counter trigger or from bit 0 or bit 4, copies the latch to the pin. After the copy, the latch inverts if the inversion enable is set: bit 1 for A, bit 5 for B, as last written.
- R10: After reset the count, the prescaler, both latches, both pins and all three flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 compare A, 1 compare B, 2 control, 3 output mode |
| wr_data | input | BUS_W | Write data |
| flag_clr | input | 3 | Write-one-to-clear strobes: bit 0 compare A, bit 1 compare B, bit 2 wrap |
| ext_ci | input | 1 | Asynchronous event input (falling edge used) |
| ext_to | input | 1 | Asynchronous timer input (falling edge used) |
| evt_count | output | CNT_W | Current counter value |
| pin_a | output | 1 | Compare output pin A |
| pin_b | output | 1 | Compare output pin B |
| flag_cmp_a | output | 1 | Compare A match flag |
| flag_cmp_b | output | 1 | Compare B match flag |
| flag_wrap | output | 1 | Free-run wrap flag |

## Verification
On every cycle the assertions check four things: the counter only steps by one or drops to zero, the hold mode forces the count to zero, the flags stay set until cleared and the wrap flag rises only with a zero count, and a pin never changes without an event or a write. Only the bench's scenarios can show the exact cycle of each step, the trigger-code decoding per pin, the ordering of latch and output commands inside one write, the synchroniser latency of the external clear, and the alternating pattern produced by inversion.

// File: rtl/evcmp_pkg.sv
package evcmp_pkg;

  typedef enum logic [1:0] {
    CLR_HOLD = 2'b00,
    CLR_FREE = 2'b01,
    CLR_EXT  = 2'b10,
    CLR_CMPB = 2'b11
  } clr_mode_e;

  typedef enum logic [1:0] {
    TRG_OWN    = 2'b00,
    TRG_OFF    = 2'b01,
    TRG_OWN_CI = 2'b10,
    TRG_ANY    = 2'b11
  } trg_e;

  localparam logic [1:0] SEL_CMPA  = 2'd0;
  localparam logic [1:0] SEL_CMPB  = 2'd1;
  localparam logic [1:0] SEL_CTL   = 2'd2;
  localparam logic [1:0] SEL_OMODE = 2'd3;

endpackage

// File: rtl/evcmp_fall.sv
module evcmp_fall (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= din;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign fall = prev_q & ~s2_q;
endmodule

// File: rtl/evcmp_core.sv
module evcmp_core
  import evcmp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  clr_mode_e        clr_mode,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  input  logic             ext_clr,
  input  logic [2:0]       flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             match_a,
  output logic             match_b,
  output logic [2:0]       flags
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, inc;
  logic [2:0]       flag_q, flag_d, flag_set;
  logic             tick;

  always_comb begin
    tick    = (clr_mode != CLR_HOLD) && (pre_q == PRE_LAST);
    inc     = cnt_q + CNT_W'(1);
    match_a = tick && (inc == cmp_a);
    match_b = tick && (inc == cmp_b);

    if (clr_mode == CLR_HOLD) pre_d = '0;
    else if (tick)            pre_d = '0;
    else                      pre_d = pre_q + PRE_W'(1);

    cnt_d = cnt_q;
    unique case (clr_mode)
      CLR_HOLD: cnt_d = '0;
      CLR_FREE: if (tick) cnt_d = inc;
      CLR_EXT: begin
        if (ext_clr)   cnt_d = '0;
        else if (tick) cnt_d = inc;
      end
      CLR_CMPB: if (tick) cnt_d = match_b ? '0 : inc;
      default:  cnt_d = cnt_q;
    endcase

    flag_set[0] = match_a;
    flag_set[1] = match_b;
    flag_set[2] = tick && (clr_mode == CLR_FREE) && (inc == '0);
    flag_d      = (flag_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      cnt_q  <= '0;
      flag_q <= '0;
    end else begin
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt   = cnt_q;
  assign flags = flag_q;

  a_r1_step_or_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0)));

  a_r4_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mode == CLR_HOLD) |=> (cnt_q == '0));

  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !flag_clr[0]) |=> flag_q[0]);

  a_r4_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q[2]) |-> (cnt_q == '0));
endmodule

// File: rtl/evcmp_pin.sv
module evcmp_pin (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic wr,
  input  logic cmd_out,
  input  logic inv_new,
  input  logic cmd_clr,
  input  logic cmd_set,
  output logic pin
);
  logic lvl_q, lvl_d, pin_q, pin_d, inv_q, inv_d;

  always_comb begin
    lvl_d = lvl_q;
    pin_d = pin_q;
    inv_d = inv_q;
    if (evt) begin
      pin_d = lvl_q;
      if (inv_q) lvl_d = ~lvl_q;
    end
    if (wr) begin
      inv_d = inv_new;
      if (cmd_clr && !cmd_set)      lvl_d = 1'b0;
      else if (cmd_set && !cmd_clr) lvl_d = 1'b1;
      if (cmd_out) begin
        pin_d = lvl_d;
        if (inv_new) lvl_d = ~lvl_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      pin_q <= 1'b0;
      inv_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      pin_q <= pin_d;
      inv_q <= inv_d;
    end
  end

  assign pin = pin_q;

  a_r9_pin_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && !wr) |=> $stable(pin_q));
endmodule

// File: rtl/evcmp_top.sv
module evcmp_top
  import evcmp_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int PRESCALE = 12,
  parameter int BUS_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [BUS_W-1:0] wr_data,
  input  logic [2:0]       flag_clr,
  input  logic             ext_ci,
  input  logic             ext_to,
  output logic [CNT_W-1:0] evt_count,
  output logic             pin_a,
  output logic             pin_b,
  output logic             flag_cmp_a,
  output logic             flag_cmp_b,
  output logic             flag_wrap
);
  localparam int NCH = 2;

  logic [1:0]       rst_pipe;
  logic             rst_sync;
  logic [CNT_W-1:0] cmp_a_q, cmp_a_d, cmp_b_q, cmp_b_d;
  logic [7:2]       ctl_q, ctl_d;
  logic             om_wr;
  logic             ci_fall, to_fall;
  logic             match_a, match_b;
  logic [2:0]       flags;
  logic [NCH-1:0]   pins;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync = rst_pipe[1];

  always_comb begin
    cmp_a_d = cmp_a_q;
    cmp_b_d = cmp_b_q;
    ctl_d   = ctl_q;
    if (wr_en) begin
      unique case (wr_sel)
        SEL_CMPA: cmp_a_d = wr_data[CNT_W-1:0];
        SEL_CMPB: cmp_b_d = wr_data[CNT_W-1:0];
        SEL_CTL:  ctl_d   = wr_data[7:2];
        default:  ;
      endcase
    end
  end
  assign om_wr = wr_en && (wr_sel == SEL_OMODE);

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      cmp_a_q <= '0;
      cmp_b_q <= '0;
      ctl_q   <= '0;
    end else begin
      cmp_a_q <= cmp_a_d;
      cmp_b_q <= cmp_b_d;
      ctl_q   <= ctl_d;
    end
  end

  evcmp_fall u_ci_fall (.clk(clk), .rst_n(rst_sync), .din(ext_ci), .fall(ci_fall));
  evcmp_fall u_to_fall (.clk(clk), .rst_n(rst_sync), .din(ext_to), .fall(to_fall));

  evcmp_core #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_core (
    .clk      (clk),
    .rst_n    (rst_sync),
    .clr_mode (clr_mode_e'(ctl_q[3:2])),
    .cmp_a    (cmp_a_q),
    .cmp_b    (cmp_b_q),
    .ext_clr  (ci_fall | to_fall),
    .flag_clr (flag_clr),
    .cnt      (evt_count),
    .match_a  (match_a),
    .match_b  (match_b),
    .flags    (flags)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    trg_e code;
    logic own_m, trig;
    assign code  = trg_e'(ctl_q[4+2*ch +: 2]);
    assign own_m = (ch == 0) ? match_a : match_b;
    always_comb begin
      unique case (code)
        TRG_OWN:    trig = own_m;
        TRG_OFF:    trig = 1'b0;
        TRG_OWN_CI: trig = own_m | ci_fall;
        TRG_ANY:    trig = match_a | match_b;
        default:    trig = 1'b0;
      endcase
    end
    evcmp_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_sync),
      .evt     (trig),
      .wr      (om_wr),
      .cmd_out (wr_data[4*ch]),
      .inv_new (wr_data[4*ch+1]),
      .cmd_clr (wr_data[4*ch+2]),
      .cmd_set (wr_data[4*ch+3]),
      .pin     (pins[ch])
    );
  end

  assign pin_a      = pins[0];
  assign pin_b      = pins[1];
  assign flag_cmp_a = flags[0];
  assign flag_cmp_b = flags[1];
  assign flag_wrap  = flags[2];
endmodule

// File: tb/evcmp_top_tb.sv
module evcmp_top_tb;
  localparam int CW = 4;
  localparam int PS = 3;
  localparam int BW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = 2'd0;
  logic [BW-1:0] wr_data = '0;
  logic [2:0]    flag_clr = 3'd0;
  logic          ext_ci = 1'b1;
  logic          ext_to = 1'b1;
  logic [CW-1:0] evt_count;
  logic          pin_a, pin_b, flag_cmp_a, flag_cmp_b, flag_wrap;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  evcmp_top #(.CNT_W(CW), .PRESCALE(PS), .BUS_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .flag_clr(flag_clr), .ext_ci(ext_ci), .ext_to(ext_to), .evt_count(evt_count),
    .pin_a(pin_a), .pin_b(pin_b), .flag_cmp_a(flag_cmp_a), .flag_cmp_b(flag_cmp_b),
    .flag_wrap(flag_wrap)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic clr_flags();
    @(negedge clk);
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
  endtask

  // ctl = {trg_b, trg_a, clear mode, 2'b00}; restart passes through hold mode
  task automatic restart(input logic [1:0] tb, input logic [1:0] ta, input logic [1:0] cm);
    wr(2'd2, {tb, ta, 2'b00, 2'b00});
    clr_flags();
    wr(2'd2, {tb, ta, cm, 2'b00});
  endtask

  task automatic adv(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R10 reset state
    chk("R10 count", int'(evt_count), 0);
    chk("R10 pin_a", pin_a, 0);
    chk("R10 pin_b", pin_b, 0);
    chk("R10 flags", {flag_cmp_a, flag_cmp_b, flag_wrap}, 0);

    // R4 hold mode keeps count zero
    wr(2'd2, 8'h00);
    adv(30);
    chk("R4 hold count", int'(evt_count), 0);
    chk("R4 hold flags", {flag_cmp_a, flag_cmp_b}, 0);

    // R1 R2 sweep of compare A
    wr(2'd1, 8'd0);
    for (int c = 1; c < 16; c++) begin
      wr(2'd0, 8'(c));
      restart(2'b00, 2'b00, 2'b01);
      adv(PS*c - 1);
      chk("R1 count before step", int'(evt_count), c-1);
      chk("R2 flag_a before match", flag_cmp_a, 0);
      adv(1);
      chk("R1 count at step", int'(evt_count), c);
      chk("R2 flag_a at match", flag_cmp_a, 1);
    end

    // R4 wrap flag, R2 clear strobe
    restart(2'b00, 2'b00, 2'b01);
    adv(PS*16 - 1);
    chk("R4 wrap before", flag_wrap, 0);
    chk("R4 count 15", int'(evt_count), 15);
    adv(1);
    chk("R4 wrap set", flag_wrap, 1);
    chk("R4 count wrapped", int'(evt_count), 0);
    @(negedge clk); flag_clr = 3'b100;
    @(negedge clk); flag_clr = 3'b000;
    #1;
    chk("R2 wrap cleared", flag_wrap, 0);
    chk("R2 flag_a kept", flag_cmp_a, 1);

    // R5 clear on compare B
    wr(2'd1, 8'd5);
    restart(2'b00, 2'b00, 2'b11);
    for (int k = 1; k <= 12; k++) begin
      adv(PS);
      chk("R5 count", int'(evt_count), k % 5);
    end
    chk("R5 flag_b", flag_cmp_b, 1);
    chk("R5 no wrap flag", flag_wrap, 0);

    // R6 external clear
    restart(2'b01, 2'b01, 2'b10);
    adv(18);
    chk("R6 count 6", int'(evt_count), 6);
    @(negedge clk); ext_ci = 1'b0;
    adv(4);
    chk("R6 ci clear", int'(evt_count), 0);
    adv(2);
    chk("R6 phase kept", int'(evt_count), 1);
    @(negedge clk); ext_ci = 1'b1;
    adv(9);
    chk("R6 rising ignored", int'(evt_count), 4);
    @(negedge clk); ext_to = 1'b0;
    adv(4);
    chk("R6 to clear", int'(evt_count), 0);
    adv(2);
    chk("R6 after to clear", int'(evt_count), 1);
    @(negedge clk); ext_to = 1'b1;

    // R7 R8 R9 commands (hold mode, no counter events)
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h08);
    chk("R7 set without output", pin_a, 0);
    wr(2'd3, 8'h01);
    chk("R8 output copies latch", pin_a, 1);
    wr(2'd3, 8'h05);
    chk("R8 clear before output", pin_a, 0);
    wr(2'd3, 8'h09);
    chk("R8 set before output", pin_a, 1);
    wr(2'd3, 8'h0D);
    chk("R7 code 11 no change", pin_a, 1);
    wr(2'd3, 8'h0B);
    chk("R9 output then invert", pin_a, 1);
    wr(2'd3, 8'h03);
    chk("R9 inverted latch", pin_a, 0);
    wr(2'd3, 8'h03);
    chk("R9 inverted again", pin_a, 1);
    wr(2'd3, 8'h90);
    chk("R8 pin_b set+out", pin_b, 1);
    chk("R8 pin_a untouched", pin_a, 1);
    wr(2'd3, 8'h50);
    chk("R8 pin_b clear+out", pin_b, 0);
    wr(2'd3, 8'hB0);
    chk("R9 pin_b invert 1", pin_b, 1);
    wr(2'd3, 8'h30);
    chk("R9 pin_b invert 2", pin_b, 0);

    // R3 trigger codes, cmp_a=2 (edge 6), cmp_b=4 (edge 12)
    wr(2'd0, 8'd2);
    wr(2'd1, 8'd4);

    wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
    restart(2'b00, 2'b11, 2'b01);
    adv(6);
    chk("R3 a any at A", pin_a, 1);
    chk("R3 b own ignores A", pin_b, 0);
    adv(6);
    chk("R3 a any at B (R7 once)", pin_a, 0);
    chk("R3 b own at B", pin_b, 1);

    wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
    restart(2'b11, 2'b01, 2'b01);
    adv(6);
    chk("R3 a off", pin_a, 0);
    chk("R3 b any at A", pin_b, 1);
    adv(6);
    chk("R3 a off still", pin_a, 0);
    chk("R3 b any at B", pin_b, 0);

    wr(2'd3, 8'h55); wr(2'd3, 8'hAA);
    restart(2'b10, 2'b10, 2'b01);
    adv(6);
    chk("R3 a own_ci at A", pin_a, 1);
    chk("R3 b own_ci not at A", pin_b, 0);
    @(negedge clk); ext_ci = 1'b0;
    adv(3);
    chk("R3 a ci event", pin_a, 0);
    chk("R3 b ci event", pin_b, 1);
    adv(3);
    chk("R3 b own at B", pin_b, 0);
    chk("R3 a not at B", pin_a, 0);
    @(negedge clk); ext_ci = 1'b1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule